// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block sits next to a small in-order CPU core and decides, at each instruction boundary, whether an interrupt is taken and which vector is used. It serves two kinds of source. Event sources latch a pending flag when their input pulses. Level sources have no flag and request service only while their input is high. Each source has its own enable bit. A global enable bit gates all of them.

The core reports four things through single-cycle strobes: an ordinary instruction retiring, a return-from-interrupt, a set-global-enable and a clear-global-enable. From these the block keeps the global enable and a one-instruction guard window. When it accepts an interrupt it asserts `take_o` and drives the vector on `vec_o`. In the same step it drops the global enable and clears the flag of the winning source.

A small register port lets software read the flags and enables. Software clears flags by writing ones and loads the enable register directly. Sources are numbered with event sources first, then level sources. A lower number has higher priority.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all flags, all enables and the global enable are 0, and both `irq_o` and `take_o` are 0.
- R2: A high `evt_i[k]` sets flag k at the next clock edge. The flag stays latched while its enable or the global enable is off, and it raises a request once both are on.
- R3: A write with `reg_addr_i`=0 clears every flag whose `reg_wdata_i` bit is 1 and leaves flags with a 0 bit unchanged. If an event hits the same flag in the same cycle, the flag ends up set.
- R4: A write with `reg_addr_i`=1 loads all NSRC bits of the enable register from `reg_wdata_i`.
- R5: The request set is the enabled sources that are pending. Source k<NF is pending when its flag is set. Source NF+j is pending when `lvl_i[j]` is high. `vec_o` is the lowest index in the set. `irq_o` is high exactly when the set is non-empty, the global enable is 1 and the guard window is closed.
- R6: `take_o` = `irq_o` & `retire_i` & !`cli_i` in the same cycle. After a take, the global enable is 0 on the next cycle, and the winner's flag (if it is an event source) is cleared.
- R7: A level source has no memory. When its input falls, its request disappears in the same cycle and no flag bit is ever reported for it.
- R8: `reti_i` sets the global enable on the next cycle and opens the guard. The next `retire_i` cannot take an interrupt and closes the guard. The retire after it can take one.
- R9: `sei_i` sets the global enable with the same one-retire guard as R8.
- R10: `cli_i` stops a take in its own cycle and leaves the global enable 0 on the next cycle.
- R11: Setting the global enable inside a handler allows an enabled pending source to preempt that handler after the guard retire.
- R12: When `cli_i` coincides with `sei_i`, the clear wins and the global enable is 0.
- R13: `reg_rdata_o` shows the flags in the low NF bits, with zeros above, when `reg_addr_i`=0. It shows the enables when `reg_addr_i`=1. Both reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NF | Event inputs; a high level sets the matching flag |
| lvl_i | input | NL | Level request inputs |
| retire_i | input | 1 | An ordinary instruction retires (boundary) |
| reti_i | input | 1 | Return-from-interrupt executes |
| sei_i | input | 1 | Set-global-enable executes |
| cli_i | input | 1 | Clear-global-enable executes |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = flags (write-one-to-clear), 1 = enables |
| reg_wdata_i | input | NSRC | Register write data |
| reg_rdata_o | output | NSRC | Register read data |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | VW | Index of the winning source |
| take_o | output | 1 | Interrupt accepted at this boundary |
| gie_o | output | 1 | Current global enable |

## Verification
`irq_o`, `vec_o`, `take_o` and `reg_rdata_o` are combinational, so each is due in the same cycle as the state and strobes it depends on. The bench therefore checks them one time step after it drives the inputs, before the clock edge. Flags, enables, the guard and the global enable change at the edge that samples their cause. Their effects are checked one time step after that edge. A sweep covers every combination of flag, level and enable patterns for six sources. Directed sequences then step through the guard, clear and nesting orderings one retire at a time.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic {
    REG_FLAGS = 1'b0,
    REG_EN    = 1'b1
  } irqc_reg_e;

  function automatic logic gie_next(logic cur, logic clr, logic take, logic setb);
    if (clr)       return 1'b0;
    else if (take) return 1'b0;
    else if (setb) return 1'b1;
    return cur;
  endfunction

  function automatic logic guard_next(logic cur, logic arm, logic boundary);
    if (arm)           return 1'b1;
    else if (boundary) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] evt_i,
  input  logic [NF-1:0] w1c_i,
  input  logic [NF-1:0] ack_i,
  output logic [NF-1:0] flag_o
);
  for (genvar k = 0; k < NF; k++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (!rst_n)        f_q <= 1'b0;
      else if (evt_i[k]) f_q <= 1'b1;
      else if (w1c_i[k] || ack_i[k]) f_q <= 1'b0;
    end
    assign flag_o[k] = f_q;
  end
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int N  = 6,
  parameter int VW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [VW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  always_comb begin
    idx_o    = '0;
    onehot_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        idx_o    = VW'(k);
        onehot_o = N'(1) << k;
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic retire_i,
  input  logic reti_i,
  input  logic sei_i,
  input  logic cli_i,
  input  logic req_any_i,
  output logic gie_o,
  output logic guard_o,
  output logic irq_o,
  output logic take_o
);
  logic gie_q, guard_q;

  assign irq_o  = req_any_i & gie_q & ~guard_q;
  assign take_o = irq_o & retire_i & ~cli_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q   <= 1'b0;
      guard_q <= 1'b0;
    end else begin
      gie_q   <= gie_next(gie_q, cli_i, take_o, reti_i | sei_i);
      guard_q <= guard_next(guard_q, reti_i | sei_i, retire_i);
    end
  end

  assign gie_o   = gie_q;
  assign guard_o = guard_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NF   = 4,
  parameter int NL   = 2,
  parameter int NSRC = NF + NL,
  parameter int VW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NF-1:0]   evt_i,
  input  logic [NL-1:0]   lvl_i,
  input  logic            retire_i,
  input  logic            reti_i,
  input  logic            sei_i,
  input  logic            cli_i,
  input  logic            reg_wr_i,
  input  logic            reg_addr_i,
  input  logic [NSRC-1:0] reg_wdata_i,
  output logic [NSRC-1:0] reg_rdata_o,
  output logic            irq_o,
  output logic [VW-1:0]   vec_o,
  output logic            take_o,
  output logic            gie_o
);
  logic [NF-1:0]   flag_q;
  logic [NF-1:0]   w1c_w;
  logic [NF-1:0]   ack_w;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] pend_w;
  logic [NSRC-1:0] req_w;
  logic [NSRC-1:0] win_w;
  logic            req_any_w;
  logic            guard_w;
  logic            wr_flags_w, wr_en_w;

  assign wr_flags_w = reg_wr_i && (irqc_reg_e'(reg_addr_i) == REG_FLAGS);
  assign wr_en_w    = reg_wr_i && (irqc_reg_e'(reg_addr_i) == REG_EN);
  assign w1c_w      = wr_flags_w ? reg_wdata_i[NF-1:0] : '0;
  assign ack_w      = take_o ? win_w[NF-1:0] : '0;

  irqc_flag_bank #(.NF(NF)) flags_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .w1c_i(w1c_w), .ack_i(ack_w), .flag_o(flag_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       en_q <= '0;
    else if (wr_en_w) en_q <= reg_wdata_i;
  end

  assign pend_w = {lvl_i, flag_q};
  assign req_w  = pend_w & en_q;

  irqc_prio_pick #(.N(NSRC), .VW(VW)) pick_i (
    .req_i(req_w), .any_o(req_any_w), .idx_o(vec_o), .onehot_o(win_w)
  );

  irqc_gate gate_i (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .reti_i(reti_i),
    .sei_i(sei_i), .cli_i(cli_i), .req_any_i(req_any_w),
    .gie_o(gie_o), .guard_o(guard_w), .irq_o(irq_o), .take_o(take_o)
  );

  assign reg_rdata_o = (irqc_reg_e'(reg_addr_i) == REG_EN) ? en_q : NSRC'(flag_q);
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NF   = 4,
  parameter int NL   = 2,
  parameter int NSRC = NF + NL,
  parameter int VW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NF-1:0]   evt_i,
  input logic            reti_i,
  input logic            sei_i,
  input logic            cli_i,
  input logic            take_o,
  input logic            irq_o,
  input logic            gie_o,
  input logic            guard_w,
  input logic [VW-1:0]   vec_o,
  input logic [NSRC-1:0] en_q,
  input logic [NF-1:0]   flag_q,
  input logic [NF-1:0]   ack_w
);
  logic [NSRC-1:0] flag_ext, evt_ext;
  assign flag_ext = NSRC'(flag_q);
  assign evt_ext  = NSRC'(evt_i);

  AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !gie_o); // R6
  AST_RETURN_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !cli_i && !take_o) |=> (gie_o && guard_w)); // R8
  AST_SEI_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (sei_i && !cli_i && !take_o) |=> (gie_o && guard_w)); // R9
  AST_GUARD_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    guard_w |-> !take_o); // R8
  AST_CLI_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    cli_i |-> !take_o); // R10
  AST_CLI_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cli_i |=> !gie_o); // R10
  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> en_q[vec_o]); // R5
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie_o); // R5
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_w)); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !evt_ext[vec_o]) |=> !flag_ext[$past(vec_o)]); // R6

  for (genvar k = 0; k < NF; k++) begin : g_evt
    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[k] |=> flag_q[k]); // R3
  end
endmodule

bind irq_prio_ctrl irqc_chk #(.NF(NF), .NL(NL), .NSRC(NSRC), .VW(VW)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reti_i(reti_i), .sei_i(sei_i),
  .cli_i(cli_i), .take_o(take_o), .irq_o(irq_o), .gie_o(gie_o),
  .guard_w(guard_w), .vec_o(vec_o), .en_q(en_q), .flag_q(flag_q), .ack_w(ack_w)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
  localparam int NF = 4, NL = 2, NSRC = 6, VW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NF-1:0] evt = '0;
  logic [NL-1:0] lvl = '0;
  logic retire = 0, reti = 0, sei = 0, cli = 0, wr = 0, addr = 0;
  logic [NSRC-1:0] wdata = '0, rdata;
  logic irq, take, gie;
  logic [VW-1:0] vec;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl #(.NF(NF), .NL(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .lvl_i(lvl), .retire_i(retire),
    .reti_i(reti), .sei_i(sei), .cli_i(cli), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .vec_o(vec),
    .take_o(take), .gie_o(gie)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wreg(input logic a, input logic [NSRC-1:0] d);
    wr = 1; addr = a; wdata = d; tick; wr = 0; addr = 0;
  endtask

  task automatic pulse_evt(input logic [NF-1:0] e);
    evt = e; tick; evt = '0;
  endtask

  task automatic do_retire(input bit exp_take, input int exp_vec, input string req);
    retire = 1; #1;
    chk(take == exp_take, req, take, exp_take);
    if (exp_take) chk(vec == VW'(exp_vec), req, vec, exp_vec);
    tick; retire = 0;
  endtask

  function automatic int lowest(input logic [NSRC-1:0] r);
    for (int k = 0; k < NSRC; k++) if (r[k]) return k;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    rst_n = 1; #1;
    // R1 reset state
    chk(irq == 0 && take == 0 && gie == 0, "R1", {irq, take, gie}, 0);
    addr = 0; #1; chk(rdata == 0, "R1 flags", rdata, 0);
    addr = 1; #1; chk(rdata == 0, "R1 enables", rdata, 0);
    addr = 0;
    // R9 open global enable: guard retire does not take
    sei = 1; tick; sei = 0;
    chk(gie == 1, "R9 gie", gie, 1);
    do_retire(0, 0, "R9 guard");
    // R2 R3 R4 R5 R13 sweep
    for (int p = 0; p < 64; p++) begin
      for (int e = 0; e < 64; e++) begin
        logic [NSRC-1:0] req;
        wr = 1; addr = 0; wdata = '1; evt = p[3:0]; tick; evt = '0;
        wdata = NSRC'(e); addr = 1; lvl = p[5:4]; tick; wr = 0;
        addr = 0; #1;
        req = NSRC'(p) & NSRC'(e);
        chk(irq == (req != 0), "R5 irq", irq, int'(req != 0));
        if (req != 0) chk(vec == VW'(lowest(req)), "R5 vec", vec, lowest(req));
        if (e == 63) chk(rdata == NSRC'(p[3:0]), "R3 set wins", rdata, p[3:0]);
        if (p == 0) begin
          addr = 1; #1; chk(rdata == NSRC'(e), "R4 R13 enables", rdata, e); addr = 0;
        end
      end
    end
    lvl = '0; wreg(0, '1); wreg(1, '1);
    // R6 take clears gie and flag
    pulse_evt(4'b0100); #1;
    chk(irq == 1 && vec == 2, "R5 single", vec, 2);
    do_retire(1, 2, "R6 take");
    chk(gie == 0, "R6 gie", gie, 0);
    chk(rdata == 0, "R6 flag ack", rdata, 0);
    // R8 return guard
    pulse_evt(4'b0010); #1;
    chk(irq == 0, "R5 gie off", irq, 0);
    reti = 1; tick; reti = 0;
    chk(gie == 1, "R8 gie", gie, 1);
    do_retire(0, 0, "R8 guard");
    do_retire(1, 1, "R8 after guard");
    // R11 nested enable in handler
    pulse_evt(4'b1000);
    sei = 1; tick; sei = 0;
    do_retire(0, 0, "R11 guard");
    do_retire(1, 3, "R11 nested");
    // R10 clear wins same cycle
    reti = 1; tick; reti = 0;
    do_retire(0, 0, "R8 idle");
    pulse_evt(4'b0001);
    cli = 1; retire = 1; #1;
    chk(take == 0, "R10 same cycle", take, 0);
    tick; cli = 0; retire = 0;
    chk(gie == 0, "R10 gie", gie, 0);
    chk(rdata == 6'h01, "R2 kept", rdata, 1);
    // R12 clear beats set
    sei = 1; cli = 1; tick; sei = 0; cli = 0;
    chk(gie == 0, "R12", gie, 0);
    wreg(0, 6'h01); #1;
    chk(rdata == 0, "R3 w1c", rdata, 0);
    wreg(0, 6'h00); #1;
    chk(rdata == 0, "R3 zero write", rdata, 0);
    // R7 level sources
    sei = 1; tick; sei = 0;
    do_retire(0, 0, "R9 idle");
    lvl = 2'b01; #1;
    chk(irq == 1 && vec == 4, "R7 level", vec, 4);
    lvl = 2'b00; #1;
    chk(irq == 0, "R7 drop", irq, 0);
    chk(rdata == 0, "R7 no flag", rdata, 0);
    lvl = 2'b10; #1;
    do_retire(1, 5, "R7 take");
    lvl = 2'b00;
    // R2 latched while disabled
    wreg(1, '0);
    reti = 1; tick; reti = 0;
    do_retire(0, 0, "R8 idle2");
    pulse_evt(4'b1000); #1;
    chk(irq == 0, "R2 disabled", irq, 0);
    chk(rdata == 6'h08, "R2 latched", rdata, 8);
    wreg(1, 6'h08); #1;
    chk(irq == 1 && vec == 3, "R2 served", vec, 3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule